// File: doc/BRIEF.md
# Planar Memory Read Unit

This block forms the byte handed back to the host when it reads display memory organised as four parallel bit planes. The memory side presents all four plane bytes fetched at the read address on one 32-bit bus. The unit holds four small configuration fields, written through an indexed register port: the read mode, the plane selector, the reference colour and the plane participation mask.

In plane-select mode the unit returns the byte of one chosen plane. In compare mode it treats bit position n of the four planes as one 4-bit pixel and returns a byte whose bit n is set when that pixel equals the reference colour. Only the planes enabled in the participation mask take part in the comparison. Every read, in either mode, also raises a one-cycle latch-load pulse. The write path uses it to capture all 32 fetched bits.

A two-state controller sequences each access. `RD_IDLE` waits for a read strobe. The transition IDLE→RESP fires on a strobe. In `RD_RESP` the registered result is presented with `rd_valid` and `latch_load`. RESP→RESP fires on a back-to-back strobe, and RESP→IDLE fires when no strobe follows.

Top module: `planar_read_unit`

## Requirements
- R1: After reset `rd_valid`, `latch_load` and `rd_data` are 0. The configuration is all zero, which means plane-select mode, plane 0, reference colour 0 and an empty participation mask.
- R2: A configuration write stores a field according to its index. Index 2 takes the reference colour from `cfg_wdata[3:0]`. Index 4 takes the plane selector from `cfg_wdata[1:0]`. Index 5 takes the mode from `cfg_wdata[3]`, where 0 means plane-select and 1 means compare. Index 7 takes the participation mask from `cfg_wdata[3:0]`. All other data bits are ignored.
- R3: Writes to any other index leave every field unchanged.
- R4: In plane-select mode `rd_data` equals plane `s`, where `s` is the plane selector. Plane p occupies `plane_data[8p+7:8p]`.
- R5: In compare mode, bit n of `rd_data` is 1 exactly when `plane_data[8p+n]` equals bit p of the reference colour for every plane p whose mask bit p is 1.
- R6: In compare mode with a participation mask of 0, `rd_data` is 8'hFF whatever the plane data.
- R7: The result of a strobe sampled at one rising edge appears on `rd_data`, with `rd_valid` high, after that edge and holds for one cycle. Back-to-back strobes give one result per cycle, in order.
- R8: `latch_load` is high for exactly the cycles in which `rd_valid` is high, in both modes.
- R9: Between reads `rd_data` keeps the last result and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 4 | Configuration field index |
| cfg_wdata | input | 8 | Configuration write data |
| rd_stb | input | 1 | Read strobe, one per read |
| plane_data | input | 32 | The four plane bytes at the read address, plane p in bits 8p+7:8p |
| rd_data | output | 8 | Host read byte |
| rd_valid | output | 1 | Read result valid |
| latch_load | output | 1 | Pulse telling the write path to capture all plane bytes |

## Verification
The bench drives plane data in which every plane byte is distinct. A selector that ignores its high bit, or that picks planes in reversed order, therefore returns the wrong byte. Compare reads sweep the participation masks, including the empty mask. A design that inverted the mask sense, or that forgot the empty-mask case, would return a partial or zero byte where 8'hFF is due. Writes to unused indices, and data with stray high bits, check that nothing spills into the fields. Back-to-back strobes catch a controller that drops to idle between reads and loses a result or a latch pulse.

// File: rtl/rdu_pkg.sv
package rdu_pkg;
    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    localparam int IDX_W = 4;
    localparam logic [IDX_W-1:0] IDX_REF  = 4'h2;
    localparam logic [IDX_W-1:0] IDX_SEL  = 4'h4;
    localparam logic [IDX_W-1:0] IDX_MODE = 4'h5;
    localparam logic [IDX_W-1:0] IDX_MASK = 4'h7;
    localparam int MODE_BIT = 3;
endpackage

// File: rtl/rdu_cfg.sv
module rdu_cfg
    import rdu_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int BYTE_W = 8,
    localparam int SEL_W = $clog2(PLANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PLANES-1:0] ref_color,
    output logic [PLANES-1:0] plane_mask,
    output logic [SEL_W-1:0]  plane_sel,
    output logic              cmp_mode
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_color  <= '0;
            plane_mask <= '0;
            plane_sel  <= '0;
            cmp_mode   <= 1'b0;
        end else if (we) begin
            unique case (idx)
                IDX_REF:  ref_color  <= wdata[PLANES-1:0];
                IDX_SEL:  plane_sel  <= wdata[SEL_W-1:0];
                IDX_MODE: cmp_mode   <= wdata[MODE_BIT];
                IDX_MASK: plane_mask <= wdata[PLANES-1:0];
                default: ;
            endcase
        end
    end

    // R3
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx != IDX_REF && idx != IDX_SEL && idx != IDX_MODE && idx != IDX_MASK)
        |=> ($stable(ref_color) && $stable(plane_mask) && $stable(plane_sel) && $stable(cmp_mode)));
endmodule

// File: rtl/rdu_plane_sel.sv
module rdu_plane_sel #(
    parameter int PLANES = 4,
    parameter int BYTE_W = 8,
    localparam int SEL_W = $clog2(PLANES)
) (
    input  logic [PLANES*BYTE_W-1:0] planes,
    input  logic [SEL_W-1:0]         sel,
    output logic [BYTE_W-1:0]        byte_out
);
    always_comb begin
        byte_out = planes[sel*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/rdu_color_cmp.sv
module rdu_color_cmp #(
    parameter int PLANES = 4,
    parameter int BYTE_W = 8
) (
    input  logic [PLANES*BYTE_W-1:0] planes,
    input  logic [PLANES-1:0]        ref_color,
    input  logic [PLANES-1:0]        plane_mask,
    output logic [BYTE_W-1:0]        match
);
    logic [BYTE_W-1:0][PLANES-1:0] pixel;

    for (genvar n = 0; n < BYTE_W; n++) begin : g_pix
        for (genvar p = 0; p < PLANES; p++) begin : g_pl
            assign pixel[n][p] = planes[p*BYTE_W + n];
        end
        assign match[n] = ~|((pixel[n] ^ ref_color) & plane_mask);
    end
endmodule

// File: rtl/planar_read_unit.sv
module planar_read_unit
    import rdu_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int BYTE_W = 8,
    localparam int BUS_W = PLANES * BYTE_W,
    localparam int SEL_W = $clog2(PLANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              rd_stb,
    input  logic [BUS_W-1:0]  plane_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              latch_load
);
    logic [PLANES-1:0] ref_color;
    logic [PLANES-1:0] plane_mask;
    logic [SEL_W-1:0]  plane_sel;
    logic              cmp_mode;
    logic [BYTE_W-1:0] sel_byte;
    logic [BYTE_W-1:0] match_byte;
    logic [BYTE_W-1:0] data_q;
    rd_state_e         state_q;
    rd_state_e         state_d;

    rdu_cfg #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .idx        (cfg_idx),
        .wdata      (cfg_wdata),
        .ref_color  (ref_color),
        .plane_mask (plane_mask),
        .plane_sel  (plane_sel),
        .cmp_mode   (cmp_mode)
    );

    rdu_plane_sel #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_sel (
        .planes   (plane_data),
        .sel      (plane_sel),
        .byte_out (sel_byte)
    );

    rdu_color_cmp #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_cmp (
        .planes     (plane_data),
        .ref_color  (ref_color),
        .plane_mask (plane_mask),
        .match      (match_byte)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_stb) state_d = RD_RESP;
            RD_RESP: state_d = rd_stb ? RD_RESP : RD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // Result register: captured on each strobe, held otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      data_q <= '0;
        else if (rd_stb) data_q <= cmp_mode ? match_byte : sel_byte;
    end

    // Outputs
    always_comb begin
        rd_data    = data_q;
        rd_valid   = (state_q == RD_RESP);
        latch_load = (state_q == RD_RESP);
    end

    // R7
    result_follows_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);
    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (!rd_valid && $stable(rd_data)));
    // R8
    latch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> latch_load);
    // R6
    empty_mask_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && cmp_mode && plane_mask == '0) |=> (rd_data == {BYTE_W{1'b1}}));
    // R4
    plane0_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !cmp_mode && plane_sel == '0) |=> (rd_data == $past(plane_data[BYTE_W-1:0])));
endmodule

// File: tb/planar_read_unit_tb.sv
`timescale 1ns/1ps
module planar_read_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        rd_stb = 1'b0;
    logic [31:0] plane_data = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        latch_load;

    int checks = 0;
    int failures = 0;
    int reads_sent = 0;
    int results_seen = 0;
    bit done = 1'b0;

    // bench-side model of the configuration
    logic [3:0] m_ref = '0;
    logic [3:0] m_mask = '0;
    logic [1:0] m_sel = '0;
    logic       m_cmp = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    planar_read_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .rd_stb     (rd_stb),
        .plane_data (plane_data),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .latch_load (latch_load)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [31:0] pl);
        logic [7:0] r;
        if (m_cmp) begin
            for (int n = 0; n < 8; n++) begin
                r[n] = 1'b1;
                for (int p = 0; p < 4; p++)
                    if (m_mask[p] && pl[8*p+n] != m_ref[p]) r[n] = 1'b0;
            end
        end else begin
            r = pl[m_sel*8 +: 8];
        end
        return r;
    endfunction

    task automatic wr_cfg(input logic [3:0] idx, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
        unique case (idx)
            4'h2: m_ref  = val[3:0];
            4'h4: m_sel  = val[1:0];
            4'h5: m_cmp  = val[3];
            4'h7: m_mask = val[3:0];
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drives one strobe cycle; caller decides whether another follows
    task automatic rd_push(input logic [31:0] pl, input string req);
        @(negedge clk);
        rd_stb = 1'b1; plane_data = pl;
        exp_q.push_back(model(pl));
        tag_q.push_back(req);
        reads_sent++;
    endtask

    task automatic rd_end();
        @(negedge clk);
        rd_stb = 1'b0; plane_data = 32'hDEAD_BEEF;
    endtask

    task automatic rd_one(input logic [31:0] pl, input string req);
        rd_push(pl, req);
        rd_end();
    endtask

    // monitor: pops expected results as the design delivers them
    always @(negedge clk) begin
        #1;
        if (rst_n && rd_valid) begin
            results_seen++;
            if (exp_q.size() == 0) begin
                check("R7 unexpected result", 32'(rd_data), 32'hFFFF_FFFF);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, 32'(rd_data), 32'(e));
            end
            check("R8 latch_load", 32'(latch_load), 32'd1);
        end else if (rst_n && latch_load) begin
            check("R8 latch_load without result", 32'(latch_load), 32'd0);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 latch_load", 32'(latch_load), 32'd0);
        check("R1 rd_data", 32'(rd_data), 32'd0);
        rd_one(32'h44332211, "R1 default plane 0");

        // R4 each plane, stray high bits in selector data (R2)
        for (int s = 0; s < 4; s++) begin
            wr_cfg(4'h4, 8'hFC | 8'(s));
            rd_one(32'hA4B3C2D1, "R4 plane select");
        end
        wr_cfg(4'h4, 8'h02);
        rd_one(32'h0F1E2D3C, "R2 selector write");

        // R7 back-to-back reads
        rd_push(32'h11223344, "R7 burst 0");
        rd_push(32'h55667788, "R7 burst 1");
        rd_push(32'h99AABBCC, "R7 burst 2");
        rd_end();
        repeat (2) @(negedge clk);

        // R9 hold between reads
        held = rd_data;
        repeat (3) @(negedge clk);
        #1;
        check("R9 data held", 32'(rd_data), 32'(held));
        check("R9 valid low", 32'(rd_valid), 32'd0);

        // R5 compare mode, mode bit with stray bits (R2)
        wr_cfg(4'h5, 8'hF8);
        wr_cfg(4'h2, 8'hF5);
        wr_cfg(4'h7, 8'h0F);
        rd_one(32'hFF00FF00, "R5 full mask");
        rd_one(32'h0F0FF0F0, "R5 full mask mixed");
        wr_cfg(4'h7, 8'h03);
        rd_one(32'h12345678, "R5 mask planes 0 1");
        wr_cfg(4'h7, 8'h08);
        rd_one(32'hA5000000, "R5 mask plane 3");
        wr_cfg(4'h2, 8'h0A);
        wr_cfg(4'h7, 8'h06);
        rd_push(32'h00F0F00F, "R5 burst compare 0");
        rd_push(32'h3C3CC3C3, "R5 burst compare 1");
        rd_end();

        // R6 empty mask
        wr_cfg(4'h7, 8'hF0);
        rd_one(32'h00000000, "R6 empty mask zeros");
        rd_one(32'h5A5AA5A5, "R6 empty mask mixed");

        // R3 writes to other indices ignored
        wr_cfg(4'h7, 8'h0F);
        wr_cfg(4'h2, 8'h06);
        wr_cfg(4'h0, 8'hFF);
        wr_cfg(4'h3, 8'hFF);
        wr_cfg(4'h6, 8'h00);
        wr_cfg(4'h8, 8'h00);
        wr_cfg(4'hF, 8'h00);
        rd_one(32'h0FF0F00F, "R3 compare fields kept");

        // back to plane-select mode
        wr_cfg(4'h5, 8'hF7);
        wr_cfg(4'h1, 8'h08);
        rd_one(32'hCAFE1234, "R3 mode kept at plane-select");

        repeat (4) @(negedge clk);
        check("R7 all results delivered", 32'(results_seen), 32'(reads_sent));
        check("R7 queue drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule